// File: doc/BRIEF.md
# Dual-Bank Waveform Playback Sequencer

This block plays back a stored arbitrary waveform whose samples are split over two memories of equal depth. The first bank holds the samples with even zero-based index, the second bank holds the samples with odd zero-based index. While the sequencer is idle it holds the read enable low and parks the address at zero, so a host can fill both memories.

A start pulse makes the block issue one shared read address per clock, counting from zero up to the programmed length minus one and then wrapping. Both memories see the same address, so every read returns one pair of neighbouring samples. After a parameterised memory latency, the pair is registered onto two converter ports together with a valid strobe. A converter that runs at twice this clock and takes port 1 before port 2 then rebuilds the original sample order.

A stop pulse ends the stream after the read in progress. The pair from that read still reaches the ports, and the ports then keep their last value.

Top module: `wave_pair_player`

## Requirements
- R1: While reset is high and whenever the block is idle, `mem_rd_o` is 0 and `mem_addr_o` is 0. After reset `pair_vld_o` is 0 and both ports are 0.
- R2: A `start_i` pulse in idle with `stop_i` low and a nonzero `len_i` puts the block in play from the next cycle: `mem_rd_o` is 1 and `mem_addr_o` is 0. A start with `len_i` equal to 0 is ignored.
- R3: While playing, the address goes up by one each cycle and returns to 0 after the value length−1. The length is captured at start, and changes to `len_i` during play have no effect.
- R4: Each read at address a sends the first-bank word (sample 2a) to `port1_o` and the second-bank word (sample 2a+1) to `port2_o`, in the same cycle. Taking port 1 and then port 2 of each valid pair gives samples 0 to 2L−1 in order, repeated.
- R5: `pair_vld_o` goes high exactly RD_LAT+1 cycles after the cycle in which the matching read was issued, and the ports update in that same cycle.
- R6: When `stop_i` is sampled high during play, that cycle's read is the last one. From the next cycle the block is idle. The pair from every read issued is still delivered. With `pair_vld_o` low, both ports hold their value.
- R7: A `start_i` pulse while playing is ignored, and the address sequence continues without a restart.
- R8: In idle, `start_i` and `stop_i` high together leave the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair-rate clock (half the converter clock) |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin playback |
| stop_i | input | 1 | End playback after the current read |
| len_i | input | ADDR_W | Waveform length in sample pairs |
| mem_addr_o | output | ADDR_W | Shared read address to both banks |
| mem_rd_o | output | 1 | Read enable to both banks |
| bank_odd_i | input | DATA_W | Read data from bank I (even zero-based samples) |
| bank_even_i | input | DATA_W | Read data from bank II (odd zero-based samples) |
| port1_o | output | DATA_W | Converter port 1 word |
| port2_o | output | DATA_W | Converter port 2 word |
| pair_vld_o | output | 1 | Ports carry a new pair this cycle |

## Verification
On every cycle the assertions check the address discipline: the address is parked in idle, steps by one, wraps at the captured length, stays inside the bound, and the length is frozen during play. They also check the start and stop transitions and that the ports hold while no pair is valid. Only the bench scenarios can show the data path. The bench rebuilds the interleaved stream from two modelled banks and compares it with the original sample list, measures the read-to-port latency, and counts reads against delivered pairs after a stop. It also exercises the ignored starts (zero length, restart during play, start with stop).

// File: rtl/wpp_pkg.sv
package wpp_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_PLAY = 1'b1
    } phase_e;

    typedef struct packed {
        logic go;
        logic halt;
    } cmd_t;

    localparam int WPP_MAX_AW = 32;

    // next address of a wrapping counter that ends at 'last'
    function automatic logic [WPP_MAX_AW-1:0] wrap_step(
        input logic [WPP_MAX_AW-1:0] cur,
        input logic [WPP_MAX_AW-1:0] last
    );
        if (cur >= last) return '0;
        return cur + 1;
    endfunction

endpackage

// File: rtl/wpp_ctrl.sv
module wpp_ctrl
    import wpp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic              rd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] len_o
);
    localparam int PADW = WPP_MAX_AW - ADDR_W;

    phase_e            ph_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] len_q;
    logic [ADDR_W-1:0] last_w;
    logic [WPP_MAX_AW-1:0] step_w;
    logic              launch_w;

    assign last_w   = len_q - 1'b1;
    assign step_w   = wrap_step({{PADW{1'b0}}, addr_q}, {{PADW{1'b0}}, last_w});
    assign launch_w = cmd_i.go && !cmd_i.halt && (len_i != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            addr_q <= '0;
            len_q  <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    addr_q <= '0;
                    if (launch_w) begin
                        ph_q  <= PH_PLAY;
                        len_q <= len_i;
                    end
                end
                PH_PLAY: begin
                    if (cmd_i.halt) begin
                        ph_q   <= PH_IDLE;
                        addr_q <= '0;
                    end else begin
                        addr_q <= step_w[ADDR_W-1:0];
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign rd_o   = (ph_q == PH_PLAY);
    assign addr_o = addr_q;
    assign len_o  = len_q;

endmodule

// File: rtl/wpp_align.sv
module wpp_align #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_i,
    output logic tap_o
);
    logic [LAT-1:0] pipe_q;

    generate
        for (genvar s = 0; s < LAT; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[0] <= 1'b0;
                    else     pipe_q[0] <= rd_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[s] <= 1'b0;
                    else     pipe_q[s] <= pipe_q[s-1];
                end
            end
        end
    endgenerate

    assign tap_o = pipe_q[LAT-1];

endmodule

// File: rtl/wpp_out.sv
module wpp_out #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take_i,
    input  logic [DATA_W-1:0] odd_i,
    input  logic [DATA_W-1:0] even_i,
    output logic [DATA_W-1:0] p1_o,
    output logic [DATA_W-1:0] p2_o,
    output logic              vld_o
);
    typedef struct packed {
        logic [DATA_W-1:0] first;
        logic [DATA_W-1:0] second;
    } pair_t;

    pair_t hold_q;
    logic  vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            vld_q <= take_i;
            if (take_i) begin
                hold_q.first  <= odd_i;
                hold_q.second <= even_i;
            end
        end
    end

    assign p1_o  = hold_q.first;
    assign p2_o  = hold_q.second;
    assign vld_o = vld_q;

endmodule

// File: rtl/wave_pair_player.sv
module wave_pair_player
    import wpp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 14,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] bank_odd_i,
    input  logic [DATA_W-1:0] bank_even_i,
    output logic [DATA_W-1:0] port1_o,
    output logic [DATA_W-1:0] port2_o,
    output logic              pair_vld_o
);
    cmd_t              cmd_w;
    logic              rd_w;
    logic              take_w;
    logic [ADDR_W-1:0] len_live;

    assign cmd_w.go   = start_i;
    assign cmd_w.halt = stop_i;

    wpp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd_w),
        .len_i  (len_i),
        .rd_o   (rd_w),
        .addr_o (mem_addr_o),
        .len_o  (len_live)
    );

    assign mem_rd_o = rd_w;

    wpp_align #(.LAT(RD_LAT)) u_align (
        .clk   (clk),
        .rst   (rst),
        .rd_i  (rd_w),
        .tap_o (take_w)
    );

    wpp_out #(.DATA_W(DATA_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .take_i (take_w),
        .odd_i  (bank_odd_i),
        .even_i (bank_even_i),
        .p1_o   (port1_o),
        .p2_o   (port2_o),
        .vld_o  (pair_vld_o)
    );

endmodule

// File: rtl/wpp_checker.sv
module wpp_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              stop_i,
    input logic [ADDR_W-1:0] len_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rd_o,
    input logic [DATA_W-1:0] port1_o,
    input logic [DATA_W-1:0] port2_o,
    input logic              pair_vld_o,
    input logic [ADDR_W-1:0] len_q
);
    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_o |-> mem_addr_o == '0); // R1

    AST_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_o && start_i && !stop_i && len_i != '0) |=> (mem_rd_o && mem_addr_o == '0)); // R2

    AST_ZERO_LEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_o && len_i == '0) |=> !mem_rd_o); // R2

    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> mem_addr_o < len_q); // R3

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !stop_i && mem_addr_o != len_q - 1'b1)
        |=> (mem_rd_o && mem_addr_o == $past(mem_addr_o) + 1'b1)); // R7

    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !stop_i && mem_addr_o == len_q - 1'b1) |=> (mem_rd_o && mem_addr_o == '0)); // R3

    AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && $past(mem_rd_o)) |-> $stable(len_q)); // R3

    AST_HALT: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && stop_i) |=> !mem_rd_o); // R6

    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pair_vld_o |-> ($stable(port1_o) && $stable(port2_o))); // R6

    AST_BOTH_CMDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_o && start_i && stop_i) |=> !mem_rd_o); // R8

endmodule

bind wave_pair_player wpp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .len_i      (len_i),
    .mem_addr_o (mem_addr_o),
    .mem_rd_o   (mem_rd_o),
    .port1_o    (port1_o),
    .port2_o    (port2_o),
    .pair_vld_o (pair_vld_o),
    .len_q      (len_live)
);

// File: tb/wave_pair_player_tb.sv
module wave_pair_player_tb;
    localparam int AW     = 8;
    localparam int DW     = 14;
    localparam int RD_LAT = 2;
    localparam int DEPTH  = 1 << AW;

    typedef struct packed {
        logic [7:0]  len;
        logic [15:0] run;
        logic [7:0]  restart_at;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1,   16'd5,   8'd0},
        '{8'd2,   16'd9,   8'd0},
        '{8'd5,   16'd12,  8'd0},
        '{8'd7,   16'd7,   8'd0},
        '{8'd6,   16'd14,  8'd4},
        '{8'd16,  16'd40,  8'd0},
        '{8'd255, 16'd600, 8'd0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          stop_i = 1'b0;
    logic [AW-1:0] len_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic          mem_rd_o;
    logic [DW-1:0] bank_odd_i;
    logic [DW-1:0] bank_even_i;
    logic [DW-1:0] port1_o;
    logic [DW-1:0] port2_o;
    logic          pair_vld_o;

    always #4 clk = ~clk;

    wave_pair_player #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(RD_LAT)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .len_i(len_i),
        .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o),
        .bank_odd_i(bank_odd_i), .bank_even_i(bank_even_i),
        .port1_o(port1_o), .port2_o(port2_o), .pair_vld_o(pair_vld_o)
    );

    function automatic logic [DW-1:0] samp(input int j);
        return DW'((j * 2731 + 1234) % (1 << DW));
    endfunction

    // bank models with RD_LAT cycles of read latency
    logic [DW-1:0]   bank1 [DEPTH];
    logic [DW-1:0]   bank2 [DEPTH];
    logic [2*DW-1:0] mpipe [RD_LAT];

    always @(posedge clk) begin
        mpipe[0] <= {bank1[mem_addr_o], bank2[mem_addr_o]};
        for (int i = 1; i < RD_LAT; i++) mpipe[i] <= mpipe[i-1];
    end
    assign bank_odd_i  = mpipe[RD_LAT-1][2*DW-1:DW];
    assign bank_even_i = mpipe[RD_LAT-1][DW-1:0];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    int exp_len = 1;
    int rd_cnt = 0;
    int vld_cnt = 0;
    int first_rd = -1;
    int first_vld = -1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    // stream monitor
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (mem_rd_o) begin
                if (rd_cnt == 0) first_rd = cyc;
                chk("R3 address", 32'(mem_addr_o), 32'(rd_cnt % exp_len));
                rd_cnt++;
            end
            if (pair_vld_o) begin
                int a;
                a = vld_cnt % exp_len;
                if (vld_cnt == 0) first_vld = cyc;
                chk("R4 port1 sample", 32'(port1_o), 32'(samp(2 * a)));
                chk("R4 port2 sample", 32'(port2_o), 32'(samp(2 * a + 1)));
                vld_cnt++;
            end
        end
    end

    task automatic play(input vec_t v);
        logic [DW-1:0] h1, h2;
        rd_cnt = 0; vld_cnt = 0; first_rd = -1; first_vld = -1;
        exp_len = int'(v.len);
        @(negedge clk);
        len_i = v.len; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        len_i = 8'd3;                       // R3: ignored during play
        for (int k = 1; k < int'(v.run); k++) begin
            @(negedge clk);
            start_i = (v.restart_at != 0 && k == int'(v.restart_at));   // R7
        end
        start_i = 1'b0;
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R6 idle after stop", 32'(mem_rd_o), 32'd0);
        chk("R1 idle address", 32'(mem_addr_o), 32'd0);
        repeat (RD_LAT + 3) @(negedge clk);
        chk("R7 R6 read count", 32'(rd_cnt), 32'(v.run));
        chk("R6 delivered pairs", 32'(vld_cnt), 32'(rd_cnt));
        chk("R5 latency", 32'(first_vld - first_rd), 32'(RD_LAT + 1));
        h1 = port1_o; h2 = port2_o;
        repeat (5) @(negedge clk);
        chk("R6 hold port1", 32'(port1_o), 32'(h1));
        chk("R6 hold port2", 32'(port2_o), 32'(h2));
        chk("R6 valid low", 32'(pair_vld_o), 32'd0);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            bank1[a] = samp(2 * a);
            bank2[a] = samp(2 * a + 1);
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 rd in reset", 32'(mem_rd_o), 32'd0);
        chk("R1 addr in reset", 32'(mem_addr_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 32'(pair_vld_o), 32'd0);
        chk("R1 port1 after reset", 32'(port1_o), 32'd0);
        chk("R1 port2 after reset", 32'(port2_o), 32'd0);
        mon_en = 1'b1;

        for (int v = 0; v < NVEC; v++) play(VECS[v]);

        // R2: zero length start ignored
        rd_cnt = 0;
        @(negedge clk);
        len_i = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 zero length", 32'(rd_cnt), 32'd0);

        // R8: start together with stop in idle
        @(negedge clk);
        len_i = 8'd4; start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 start with stop", 32'(rd_cnt), 32'd0);
        chk("R8 valid low", 32'(pair_vld_o), 32'd0);

        // R2: first address after a launch
        exp_len = 3; rd_cnt = 0; vld_cnt = 0;
        @(negedge clk);
        len_i = 8'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 launched", 32'(mem_rd_o), 32'd1);
        chk("R2 first address", 32'(mem_addr_o), 32'd0);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        repeat (RD_LAT + 3) @(negedge clk);
        chk("R6 single pair", 32'(vld_cnt), 32'd1);

        finish_run();
    end

endmodule